// File: doc/BRIEF.md
# Two-Lane Issue Commit Controller

This block sits at the end of a two-lane, in-order thread pipeline. It decides, once per thread cycle, what the issue slot now leaving decode may actually commit. Lane 0 is the memory lane: loads, stores, branches and simple arithmetic. Lane 1 is the resource lane: resource operations and simple arithmetic. An issue slot is one 32-bit aligned word. It holds either one 32-bit instruction, or two 16-bit instructions that execute side by side. In single-issue mode a slot carries exactly one instruction, of either width.

Decode presents each slot on a valid/ready handshake. The controller turns the slot into per-lane register-write enables, a store-completion strobe and a PC update. It handles four conditions that stop a commit:

- a stall in either lane, which freezes both lanes;
- a destination-register clash between paired instructions;
- a fault in one or both lanes;
- an interrupt.

When an exception or interrupt is taken, it records the PC of the issue slot, the lane involved and a 4-bit cause. The PC is then left pointing at the slot so that the slot is executed again.

Back-pressure rules: decode holds a slot steady while `slot_valid` is high and `slot_ready` is low. `slot_ready` is low whenever either lane stalls and no interrupt is pending. A pending interrupt consumes the slot even while a lane is stalled. All commit outputs are registered and describe the slot accepted on the previous clock edge.

Top module: `dlane_commit`

## Requirements
- R1: A slot is accepted on a clock edge where `slot_valid` and `slot_ready` are both high. Its results appear on the outputs for exactly the following cycle. When no slot is accepted, the following cycle shows no register write, no store and no exception.
- R2: While `mem_stall` or `res_stall` is high and `irq` is low, `slot_ready` is low. Neither lane writes, no store completes, and `next_pc` does not change.
- R3: In dual-issue mode, a fault-free slot commits the register write of each valid lane with `dst_en` set, using that lane's destination index. `next_pc` then advances by 4.
- R4: In dual-issue mode, if both lanes write the same destination index, an exception with cause 2 (clash) and lane 1 is raised, and neither lane writes. If only one lane writes a given index, there is no clash.
- R5: If exactly one lane faults, neither lane writes. The cause is 3 with lane 0 for a memory-lane fault, or 4 with lane 1 for a resource-lane fault. A store in the memory lane completes (`store_done`) whenever the memory lane itself did not fault, even if the slot raises an exception for a resource-lane fault or a clash.
- R6: If both lanes fault, only cause 3 with lane 0 is reported, and both lanes are aborted. The exception priority is: interrupt, then illegal slot, then memory fault, then resource fault, then clash.
- R7: On any exception or interrupt, `exc_valid` pulses for one cycle. `exc_pc` holds the PC of the slot and `exc_lane` holds the lane. `next_pc` stays at that PC so the slot is re-executed.
- R8: An interrupt with a valid slot is taken even during a stall. It reports cause 1 and lane 0, writes no register and completes no store.
- R9: An illegal slot reports cause 5 and lane 0 and commits nothing. A slot is illegal in these cases:
  - dual-issue mode with a PC that is not 32-bit aligned;
  - dual-issue mode with a 32-bit instruction and both lanes valid;
  - single-issue mode with an odd PC;
  - single-issue mode with a 32-bit instruction at a PC that is 2 modulo 4.
- R10: In single-issue mode, at most one instruction executes. If both lanes are valid, only the memory lane runs, and the resource lane's write and fault are ignored. A resource-lane-only slot executes in the resource lane. The clash check is off.
- R11: After a commit, `next_pc` advances by 4 in dual-issue mode or for a 32-bit instruction, and by 2 for a 16-bit instruction in single-issue mode. A taken memory-lane branch instead loads the branch target. On an exception the PC is held.
- R12: Reset sets `next_pc` to `RESET_PC` and clears all write, store and exception outputs, with cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 = dual-issue mode, 0 = single-issue |
| irq | input | 1 | Interrupt request, taken with the next slot |
| mem_stall | input | 1 | Memory lane stall |
| res_stall | input | 1 | Resource lane stall |
| slot_valid | input | 1 | Issue slot present |
| slot_ready | output | 1 | Issue slot can be consumed this cycle |
| slot_is32 | input | 1 | Slot holds one 32-bit instruction |
| m_valid | input | 1 | Memory lane holds an instruction |
| m_dst_en | input | 1 | Memory lane writes a register |
| m_dst | input | IDX_W | Memory lane destination index |
| m_is_store | input | 1 | Memory lane instruction is a store |
| m_fault | input | 1 | Memory lane instruction faults |
| m_br_taken | input | 1 | Memory lane branch is taken |
| m_br_tgt | input | PC_W | Branch target address |
| r_valid | input | 1 | Resource lane holds an instruction |
| r_dst_en | input | 1 | Resource lane writes a register |
| r_dst | input | IDX_W | Resource lane destination index |
| r_fault | input | 1 | Resource lane instruction faults |
| m_wr_en | output | 1 | Commit memory lane register write |
| m_wr_idx | output | IDX_W | Memory lane write index |
| r_wr_en | output | 1 | Commit resource lane register write |
| r_wr_idx | output | IDX_W | Resource lane write index |
| store_done | output | 1 | Let the memory lane store complete |
| next_pc | output | PC_W | PC of the next issue slot |
| exc_valid | output | 1 | Exception or interrupt taken (pulse) |
| exc_pc | output | PC_W | Saved PC of the excepting slot |
| exc_cause | output | 4 | Cause: 0 none, 1 irq, 2 clash, 3 mem fault, 4 res fault, 5 illegal slot |
| exc_lane | output | 1 | Lane reported: 0 memory, 1 resource |

## Verification
The bench targets these corner cases:

- A resource-lane stall with an interrupt arriving in the same cycle. A design that let the memory lane run ahead would show a write or a store there.
- Both lanes faulting together, and a fault combined with a destination clash. An arbiter with the wrong priority would report the resource lane or the clash cause.
- A store paired with a faulting resource instruction. A design that treated the store as aborted would drop `store_done`.
- Single-issue 16-bit steps that leave the PC at 2 modulo 4, followed by dual-issue and 32-bit slots at that PC. These must be rejected as illegal and hold the PC. A design with a weak alignment check would commit them or move the PC.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  typedef enum logic [3:0] {
    CAUSE_NONE  = 4'd0,
    CAUSE_IRQ   = 4'd1,
    CAUSE_CLASH = 4'd2,
    CAUSE_MEM   = 4'd3,
    CAUSE_RES   = 4'd4,
    CAUSE_SLOT  = 4'd5
  } exc_cause_e;

  localparam int  NUM_LANES = 2;
  localparam int  LANE_W    = $clog2(NUM_LANES);
  localparam int  MEM_LANE  = 0;
  localparam int  RES_LANE  = 1;
  localparam logic LANE_SEL_MEM = 1'b0;
  localparam logic LANE_SEL_RES = 1'b1;

endpackage

// File: rtl/dlc_lane_qual.sv
// Per-lane qualification: whether the lane executes at all, and if so
// whether it requests a register write or raises a fault.
module dlc_lane_qual (
  input  logic lane_on,
  input  logic ins_valid,
  input  logic dst_en,
  input  logic fault,
  output logic wr_req,
  output logic flt
);

  logic active;

  assign active = lane_on & ins_valid;
  assign wr_req = active & dst_en;
  assign flt    = active & fault;

endmodule

// File: rtl/dlc_clash.sv
// Destination disjointness check for paired instructions.
module dlc_clash #(
  parameter int IDX_W = 5
) (
  input  logic             check_en,
  input  logic             a_wr,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_wr,
  input  logic [IDX_W-1:0] b_idx,
  output logic             clash
);

  logic same_idx;

  assign same_idx = (a_idx == b_idx);
  assign clash    = check_en & a_wr & b_wr & same_idx;

endmodule

// File: rtl/dlc_exc_arb.sv
// Fixed-priority selection of the single exception that a slot reports.
module dlc_exc_arb
  import dlc_pkg::*;
(
  input  logic                 irq,
  input  logic                 slot_bad,
  input  logic [NUM_LANES-1:0] lane_flt,
  input  logic                 clash,
  output logic                 exc,
  output exc_cause_e           cause,
  output logic                 lane
);

  always_comb begin
    exc   = 1'b1;
    cause = CAUSE_NONE;
    lane  = LANE_SEL_MEM;
    if (irq) begin
      cause = CAUSE_IRQ;
    end else if (slot_bad) begin
      cause = CAUSE_SLOT;
    end else if (lane_flt[MEM_LANE]) begin
      cause = CAUSE_MEM;
    end else if (lane_flt[RES_LANE]) begin
      cause = CAUSE_RES;
      lane  = LANE_SEL_RES;
    end else if (clash) begin
      cause = CAUSE_CLASH;
      lane  = LANE_SEL_RES;
    end else begin
      exc   = 1'b0;
    end
  end

endmodule

// File: rtl/dlc_pc_unit.sv
// Issue-slot program counter: alignment check, advance, branch redirect.
module dlc_pc_unit #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dual_mode,
  input  logic            is32,
  input  logic            step,
  input  logic            br_take,
  input  logic [PC_W-1:0] br_tgt,
  output logic [PC_W-1:0] pc_q,
  output logic            misaligned
);

  localparam logic [PC_W-1:0] SLOT_BYTES = PC_W'(4);
  localparam logic [PC_W-1:0] HALF_BYTES = PC_W'(2);

  logic [PC_W-1:0] inc;
  logic            odd_pc;
  logic            half_pc;

  assign odd_pc  = pc_q[0];
  assign half_pc = pc_q[1];

  always_comb begin
    if (dual_mode) misaligned = odd_pc | half_pc;
    else           misaligned = odd_pc | (is32 & half_pc);
  end

  assign inc = (dual_mode | is32) ? SLOT_BYTES : HALF_BYTES;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= RESET_PC;
    else if (step) begin
      if (br_take)    pc_q <= br_tgt;
      else            pc_q <= pc_q + inc;
    end
  end

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q)); // R11

endmodule

// File: rtl/dlane_commit.sv
module dlane_commit
  import dlc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              IDX_W    = 5,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic             irq,
  input  logic             mem_stall,
  input  logic             res_stall,
  input  logic             slot_valid,
  output logic             slot_ready,
  input  logic             slot_is32,
  input  logic             m_valid,
  input  logic             m_dst_en,
  input  logic [IDX_W-1:0] m_dst,
  input  logic             m_is_store,
  input  logic             m_fault,
  input  logic             m_br_taken,
  input  logic [PC_W-1:0]  m_br_tgt,
  input  logic             r_valid,
  input  logic             r_dst_en,
  input  logic [IDX_W-1:0] r_dst,
  input  logic             r_fault,
  output logic             m_wr_en,
  output logic [IDX_W-1:0] m_wr_idx,
  output logic             r_wr_en,
  output logic [IDX_W-1:0] r_wr_idx,
  output logic             store_done,
  output logic [PC_W-1:0]  next_pc,
  output logic             exc_valid,
  output logic [PC_W-1:0]  exc_pc,
  output logic [3:0]       exc_cause,
  output logic             exc_lane
);

  // ---------------- handshake ----------------
  logic any_stall;
  logic accept;

  assign any_stall  = mem_stall | res_stall;
  assign slot_ready = ~any_stall | irq;
  assign accept     = slot_valid & slot_ready;

  // ---------------- lane qualification ----------------
  logic [NUM_LANES-1:0] ln_on, ln_v, ln_de, ln_f, wr_req, flt;

  // Single-issue: the resource lane runs only when the memory lane is idle.
  assign ln_on[MEM_LANE] = 1'b1;
  assign ln_on[RES_LANE] = dual_mode | ~m_valid;
  assign ln_v            = {r_valid,  m_valid};
  assign ln_de           = {r_dst_en, m_dst_en};
  assign ln_f            = {r_fault,  m_fault};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dlc_lane_qual u_qual (
      .lane_on   (ln_on[g]),
      .ins_valid (ln_v[g]),
      .dst_en    (ln_de[g]),
      .fault     (ln_f[g]),
      .wr_req    (wr_req[g]),
      .flt       (flt[g])
    );
  end

  // ---------------- destination clash ----------------
  logic clash;

  dlc_clash #(.IDX_W(IDX_W)) u_clash (
    .check_en (dual_mode),
    .a_wr     (wr_req[MEM_LANE]),
    .a_idx    (m_dst),
    .b_wr     (wr_req[RES_LANE]),
    .b_idx    (r_dst),
    .clash    (clash)
  );

  // ---------------- PC and slot legality ----------------
  logic            misaligned;
  logic            pair_on_32;
  logic            slot_bad;
  logic            commit;
  logic [PC_W-1:0] pc_q;

  assign pair_on_32 = dual_mode & slot_is32 & m_valid & r_valid;
  assign slot_bad   = misaligned | pair_on_32;

  // ---------------- exception arbitration ----------------
  logic       arb_exc;
  exc_cause_e arb_cause;
  logic       arb_lane;

  dlc_exc_arb u_arb (
    .irq      (irq),
    .slot_bad (slot_bad),
    .lane_flt (flt),
    .clash    (clash),
    .exc      (arb_exc),
    .cause    (arb_cause),
    .lane     (arb_lane)
  );

  assign commit = accept & ~arb_exc;

  dlc_pc_unit #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_mode  (dual_mode),
    .is32       (slot_is32),
    .step       (commit),
    .br_take    (m_valid & m_br_taken),
    .br_tgt     (m_br_tgt),
    .pc_q       (pc_q),
    .misaligned (misaligned)
  );

  // A store already on its way completes unless its own lane faulted,
  // the slot was illegal, or an interrupt pre-empted the slot.
  logic store_go;
  assign store_go = accept & ~irq & ~slot_bad & m_valid & m_is_store & ~m_fault;

  // ---------------- registered commit outputs ----------------
  exc_cause_e cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_wr_en    <= 1'b0;
      r_wr_en    <= 1'b0;
      m_wr_idx   <= '0;
      r_wr_idx   <= '0;
      store_done <= 1'b0;
      exc_valid  <= 1'b0;
      exc_pc     <= RESET_PC;
      cause_q    <= CAUSE_NONE;
      exc_lane   <= LANE_SEL_MEM;
    end else begin
      m_wr_en    <= commit & wr_req[MEM_LANE];
      r_wr_en    <= commit & wr_req[RES_LANE];
      store_done <= store_go;
      exc_valid  <= accept & arb_exc;
      if (commit) begin
        m_wr_idx <= m_dst;
        r_wr_idx <= r_dst;
      end
      if (accept & arb_exc) begin
        exc_pc   <= pc_q;
        cause_q  <= arb_cause;
        exc_lane <= arb_lane;
      end
    end
  end

  assign exc_cause = cause_q;
  assign next_pc   = pc_q;

  // ---------------- assertions ----------------
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && any_stall && !irq) |=> (!m_wr_en && !r_wr_en && !store_done)); // R2

  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!m_wr_en && !r_wr_en)); // R5

  AST_EXC_PC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (next_pc == exc_pc)); // R7

  AST_IRQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && irq) |=> (exc_valid && exc_cause == CAUSE_IRQ && !store_done)); // R8

  AST_SINGLE_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dual_mode) |=> !(m_wr_en && r_wr_en)); // R10

  AST_CLASH_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dual_mode && !irq && !slot_is32 && next_pc[1:0] == 2'b00 &&
     m_valid && r_valid && m_dst_en && r_dst_en && m_dst == r_dst &&
     !m_fault && !r_fault) |=> (exc_valid && exc_cause == CAUSE_CLASH)); // R4

  AST_NO_IDLE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |=> (!m_wr_en && !r_wr_en && !store_done && !exc_valid)); // R1

endmodule

// File: tb/test_dlane_commit.sv
`timescale 1ns/1ps
module test_dlane_commit;

  localparam int PC_W  = 32;
  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             dual_mode, irq, mem_stall, res_stall;
  logic             slot_valid, slot_ready, slot_is32;
  logic             m_valid, m_dst_en, m_is_store, m_fault, m_br_taken;
  logic [IDX_W-1:0] m_dst, r_dst;
  logic [PC_W-1:0]  m_br_tgt;
  logic             r_valid, r_dst_en, r_fault;
  logic             m_wr_en, r_wr_en, store_done, exc_valid, exc_lane;
  logic [IDX_W-1:0] m_wr_idx, r_wr_idx;
  logic [PC_W-1:0]  next_pc, exc_pc;
  logic [3:0]       exc_cause;

  always #2.5 clk = ~clk;

  dlane_commit #(.PC_W(PC_W), .IDX_W(IDX_W), .RESET_PC('0)) i_dlane_commit (
    .clk, .rst_n, .dual_mode, .irq, .mem_stall, .res_stall,
    .slot_valid, .slot_ready, .slot_is32,
    .m_valid, .m_dst_en, .m_dst, .m_is_store, .m_fault, .m_br_taken, .m_br_tgt,
    .r_valid, .r_dst_en, .r_dst, .r_fault,
    .m_wr_en, .m_wr_idx, .r_wr_en, .r_wr_idx, .store_done,
    .next_pc, .exc_valid, .exc_pc, .exc_cause, .exc_lane
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [PC_W-1:0] exp_pc;

  typedef struct packed {
    logic [3:0] req;
    logic dual, is32, mv, mde;
    logic [4:0] md;
    logic mst, mf, rv, rde;
    logic [4:0] rd;
    logic rf;
    logic xm, xr, xs, xe;
    logic [3:0] xc;
    logic xl;
    logic [2:0] adv;
  } vec_t;

  // req dual is32 mv mde md mst mf rv rde rd rf | xm xr xs xe xc xl adv
  localparam vec_t VECS [0:11] = '{
    '{4'd3, 1,0, 1,1,5'd3, 0,0, 1,1,5'd7, 0,  1,1,0,0, 4'd0,0, 3'd4}, // R3 pair commits
    '{4'd4, 1,0, 1,1,5'd5, 0,0, 1,1,5'd5, 0,  0,0,0,1, 4'd2,1, 3'd0}, // R4 clash
    '{4'd4, 1,0, 1,0,5'd5, 1,0, 1,1,5'd5, 0,  0,1,1,0, 4'd0,0, 3'd4}, // R4 no clash, one writer
    '{4'd5, 1,0, 1,0,5'd0, 1,0, 1,1,5'd9, 1,  0,0,1,1, 4'd4,1, 3'd0}, // R5 res fault, store completes
    '{4'd5, 1,0, 1,1,5'd2, 0,1, 1,1,5'd9, 0,  0,0,0,1, 4'd3,0, 3'd0}, // R5 mem fault aborts res
    '{4'd6, 1,0, 1,0,5'd0, 1,1, 1,1,5'd9, 1,  0,0,0,1, 4'd3,0, 3'd0}, // R6 both fault
    '{4'd6, 1,0, 1,1,5'd6, 0,0, 1,1,5'd6, 1,  0,0,0,1, 4'd4,1, 3'd0}, // R6 fault beats clash
    '{4'd10,0,1, 1,1,5'd4, 0,0, 1,1,5'd4, 1,  1,0,0,0, 4'd0,0, 3'd4}, // R10 res lane ignored
    '{4'd10,0,1, 0,0,5'd0, 0,0, 1,1,5'd8, 0,  0,1,0,0, 4'd0,0, 3'd4}, // R10 res-only slot
    '{4'd9, 1,1, 1,1,5'd1, 0,0, 1,1,5'd2, 0,  0,0,0,1, 4'd5,0, 3'd0}, // R9 pair on 32-bit slot
    '{4'd3, 1,1, 1,1,5'd11,0,0, 0,0,5'd0, 0,  1,0,0,0, 4'd0,0, 3'd4}, // R3 single 32-bit
    '{4'd5, 1,0, 1,0,5'd0, 1,0, 0,0,5'd0, 0,  0,0,1,0, 4'd0,0, 3'd4}  // R5 lone store
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    slot_valid = 0; slot_is32 = 0; irq = 0; mem_stall = 0; res_stall = 0;
    m_valid = 0; m_dst_en = 0; m_dst = '0; m_is_store = 0; m_fault = 0;
    m_br_taken = 0; m_br_tgt = '0;
    r_valid = 0; r_dst_en = 0; r_dst = '0; r_fault = 0;
  endtask

  // Drive one slot at a negedge, let one posedge pass, return at the next negedge.
  task automatic put_slot(input logic dual, input logic is32,
                          input logic mv, input logic mde, input logic [4:0] md,
                          input logic mst, input logic mf,
                          input logic mbr, input logic [31:0] mtgt,
                          input logic rv, input logic rde, input logic [4:0] rd,
                          input logic rf);
    dual_mode = dual; slot_is32 = is32; slot_valid = 1;
    m_valid = mv; m_dst_en = mde; m_dst = md; m_is_store = mst; m_fault = mf;
    m_br_taken = mbr; m_br_tgt = mtgt;
    r_valid = rv; r_dst_en = rde; r_dst = rd; r_fault = rf;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_exc(input string req, input logic [3:0] c,
                            input logic l, input logic [31:0] pc);
    chk(req, "exc_valid", exc_valid, 1);
    chk(req, "exc_cause", exc_cause, c);
    chk(req, "exc_lane", exc_lane, l);
    chk(req, "exc_pc", exc_pc, pc);
    chk(req, "no m write", m_wr_en, 0);
    chk(req, "no r write", r_wr_en, 0);
    chk(req, "pc held", next_pc, pc);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    dual_mode = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12", "next_pc", next_pc, 0);
    chk("R12", "m_wr_en", m_wr_en, 0);
    chk("R12", "exc_valid", exc_valid, 0);
    chk("R12", "exc_cause", exc_cause, 0);
    chk("R12", "store_done", store_done, 0);
    chk("R1", "slot_ready idle", slot_ready, 1);
    exp_pc = 0;

    // R1 no slot, no effect
    @(posedge clk); @(negedge clk);
    chk("R1", "idle no write", m_wr_en | r_wr_en | store_done | exc_valid, 0);
    chk("R1", "idle pc", next_pc, exp_pc);

    // Table walk
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      string tag;
      logic [31:0] pc0;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      pc0 = exp_pc;
      put_slot(v.dual, v.is32, v.mv, v.mde, v.md, v.mst, v.mf, 0, '0,
               v.rv, v.rde, v.rd, v.rf);
      idle_inputs();
      exp_pc = pc0 + 32'(v.adv);
      chk(tag, "m_wr_en", m_wr_en, v.xm);
      chk(tag, "r_wr_en", r_wr_en, v.xr);
      chk(tag, "store_done", store_done, v.xs);
      chk(tag, "exc_valid", exc_valid, v.xe);
      chk(tag, "next_pc", next_pc, exp_pc);
      if (v.xe) begin
        chk(tag, "exc_cause", exc_cause, v.xc);
        chk(tag, "exc_lane", exc_lane, v.xl);
        chk(tag, "exc_pc", exc_pc, pc0);
      end
      if (v.xm) chk(tag, "m_wr_idx", m_wr_idx, v.md);
      if (v.xr) chk(tag, "r_wr_idx", r_wr_idx, v.rd);
      @(posedge clk); @(negedge clk);
      chk("R1", "pulse drops", m_wr_en | r_wr_en | store_done | exc_valid, 0);
    end

    // R2 stall in memory lane, then resource lane
    mem_stall = 1;
    dual_mode = 1; slot_valid = 1; m_valid = 1; m_dst_en = 1; m_dst = 1; m_is_store = 1;
    r_valid = 1; r_dst_en = 1; r_dst = 2;
    #0.1 chk("R2", "ready low mem stall", slot_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R2", "no commit mem stall", m_wr_en | r_wr_en | store_done, 0);
    chk("R2", "pc frozen", next_pc, exp_pc);
    mem_stall = 0; res_stall = 1;
    #0.1 chk("R2", "ready low res stall", slot_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R2", "no commit res stall", m_wr_en | r_wr_en | store_done, 0);

    // R8 interrupt during resource stall
    irq = 1;
    #0.1 chk("R8", "ready with irq", slot_ready, 1);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    expect_exc("R8", 4'd1, 0, exp_pc);
    chk("R8", "no store on irq", store_done, 0);

    // R11 branch commits and redirects
    put_slot(1, 0, 1, 0, 0, 0, 0, 1, 32'h100, 1, 1, 5'd12, 0);
    idle_inputs();
    chk("R11", "branch pc", next_pc, 32'h100);
    chk("R11", "paired write", r_wr_en, 1);
    exp_pc = 32'h100;

    // R11 branch with resource fault holds PC
    put_slot(1, 0, 1, 0, 0, 0, 0, 1, 32'h300, 1, 1, 5'd12, 1);
    idle_inputs();
    expect_exc("R11", 4'd4, 1, 32'h100);

    // R10/R11 single 16-bit step by 2
    put_slot(0, 0, 1, 1, 5'd3, 0, 0, 0, '0, 0, 0, 0, 0);
    idle_inputs();
    chk("R11", "half step", next_pc, 32'h102);
    chk("R10", "single write", m_wr_en, 1);

    // R9 dual slot at half-aligned PC
    put_slot(1, 0, 1, 1, 5'd3, 0, 0, 0, '0, 1, 1, 5'd4, 0);
    idle_inputs();
    expect_exc("R9", 4'd5, 0, 32'h102);
    chk("R7", "exc pulse", exc_valid, 1);

    // R9 single 32-bit at half-aligned PC
    put_slot(0, 1, 1, 1, 5'd3, 1, 0, 0, '0, 0, 0, 0, 0);
    idle_inputs();
    expect_exc("R9", 4'd5, 0, 32'h102);
    chk("R9", "no store illegal", store_done, 0);

    // R11 single 16-bit realigns
    put_slot(0, 0, 1, 1, 5'd3, 0, 0, 0, '0, 0, 0, 0, 0);
    idle_inputs();
    chk("R11", "realigned", next_pc, 32'h104);

    // R9 odd branch target then single-issue slot
    put_slot(1, 0, 1, 0, 0, 0, 0, 1, 32'h201, 0, 0, 0, 0);
    idle_inputs();
    chk("R11", "odd target", next_pc, 32'h201);
    put_slot(0, 0, 1, 1, 5'd3, 0, 0, 0, '0, 0, 0, 0, 0);
    idle_inputs();
    expect_exc("R9", 4'd5, 0, 32'h201);

    // R12 reset mid-run
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    chk("R12", "pc after reset", next_pc, 0);
    chk("R12", "cause after reset", exc_cause, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule